// File: doc/BRIEF.md
# Debug Core Register Transfer Unit

This block gives an external debugger word access to a processor's core registers without running any code on the core. The debugger sees three word registers on a simple write/read port with byte strobes: a write-only selector, a data register and a status register. A full-word write to the selector latches a register index and a direction. The block then runs a request/acknowledge handshake with a core register file model to move one word between the data register and the chosen core register.

The status register shows a ready flag that drops while the handshake is in flight and rises again once the word has moved. The index space is sparse. It holds thirteen general registers, a "current stack pointer" alias that is routed to the main or process stack pointer by a stack-select input, the link register and a debug return address. It also holds the program status word, both stack pointers by name, and one packed word that carries four 8-bit special masks. The core register file model answers after an acknowledge latency of 1 to 8 cycles, set by an input pin, so that slow and fast cores can both be exercised.

The bus map uses byte addresses. Status is at 0x0, the selector at 0x4 and the data register at 0x8. Unaligned or unmapped addresses read as zero and ignore writes. Reads are combinational from the address.

Top module: `dbg_xfer_unit`

## Requirements
- R1: After reset the status register reads 0x0001_0000 (ready set), the data register reads 0, no transfer is pending, and every core register reads back as 0.
- R2: A full-strobe selector write with bit 16 set copies the data register into the selected core register. With bit 16 clear, it copies the selected core register into the data register.
- R3: Selector bits 4:0 choose the target. Index 0 to 12 selects the general registers, 14 the link register, 15 the debug return address, 16 the program status word, 17 the main stack pointer and 18 the process stack pointer. Each is separate storage.
- R4: Index 13 reaches the main stack pointer when stack_sel is 0 and the process stack pointer when stack_sel is 1, sampled at the selector write.
- R5: Index 20 selects a packed word: CONTROL in bits 31:24, FAULTMASK in 23:16, BASEPRI in 15:8 and PRIMASK in 7:0. All 32 bits round-trip.
- R6: Indices 19 and 21 to 31 still complete the handshake. A read through them loads 0 into the data register, and a write through them changes no core register.
- R7: Status bit 16 reads 0 from the cycle after an accepted selector write until the transfer ends. It stays 0 for exactly ack_lat + 2 cycles, with ack_lat in 0..7 giving a core latency of 1..8 cycles.
- R8: A selector write whose byte strobes are not all set is ignored. Ready stays 1 and the data register is unchanged.
- R9: A selector write made while a transfer is pending is ignored. Ready stays 0 until the first transfer ends, and the second target is untouched.
- R10: The selector reads as 0, and all status bits other than bit 16 read as 0.
- R11: Writes to the data register honour the byte strobes. Strobe bit n updates bits 8n+7:8n only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Write enable for the register port |
| bus_addr | input | ADDR_W | Byte address (status 0x0, selector 0x4, data 0x8) |
| bus_wdata | input | DATA_W | Write data |
| bus_wstrb | input | DATA_W/8 | Byte strobes for writes |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| stack_sel | input | 1 | Routing of index 13: 0 main stack pointer, 1 process stack pointer |
| ack_lat | input | LAT_W | Core acknowledge latency minus one |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 4-bit address and a 3-bit latency field. The 3-bit latency field lets it sweep every acknowledge latency from 1 to 8 cycles and check the exact length of the ready-low window at each setting. The 32-bit word lets the packed special-register word and the bit-16 direction field sit at their real positions. Directed cases reach the alias routing, the unlisted indices, partial-strobe and mid-transfer selector writes. Seeded random sequences then mix data-register byte writes, random indices, directions, stack selects and latencies against a bench model of the core storage.

// File: rtl/dbgx_pkg.sv
// Shared definitions for the debug core register transfer unit.
// Assumes a word of at least 17 bits so the direction bit fits.
package dbgx_pkg;

    localparam int IDX_W    = 5;
    localparam int SLOT_W   = 5;
    localparam int SLOT_N   = 19;
    localparam int DIR_BIT  = 16;
    localparam int RDY_BIT  = 16;

    // Word offsets of the three visible registers (byte address = ofs*4)
    localparam logic [1:0] OFS_STATUS = 2'd0;
    localparam logic [1:0] OFS_SEL    = 2'd1;
    localparam logic [1:0] OFS_DATA   = 2'd2;

    // Physical storage slots inside the core register file model
    localparam logic [SLOT_W-1:0] SL_LR   = 5'd13;
    localparam logic [SLOT_W-1:0] SL_DRA  = 5'd14;
    localparam logic [SLOT_W-1:0] SL_PSW  = 5'd15;
    localparam logic [SLOT_W-1:0] SL_MSP  = 5'd16;
    localparam logic [SLOT_W-1:0] SL_PSP  = 5'd17;
    localparam logic [SLOT_W-1:0] SL_MASK = 5'd18;

    // Layout of the packed special-mask word
    typedef struct packed {
        logic [7:0] control;
        logic [7:0] faultmask;
        logic [7:0] basepri;
        logic [7:0] primask;
    } mask_word_t;

    typedef struct packed {
        logic              ok;
        logic [SLOT_W-1:0] slot;
    } route_t;

    typedef enum logic {XS_IDLE, XS_BUSY} xfer_state_t;

    // Map a debugger index to a storage slot, resolving the stack alias
    function automatic route_t route_index(input logic [IDX_W-1:0] idx,
                                           input logic psp_sel);
        route_t r;
        r.ok   = 1'b1;
        r.slot = idx;
        case (idx)
            5'd13:   r.slot = psp_sel ? SL_PSP : SL_MSP;
            5'd14:   r.slot = SL_LR;
            5'd15:   r.slot = SL_DRA;
            5'd16:   r.slot = SL_PSW;
            5'd17:   r.slot = SL_MSP;
            5'd18:   r.slot = SL_PSP;
            5'd20:   r.slot = SL_MASK;
            default: begin
                if (idx > 5'd12) begin
                    r.ok   = 1'b0;
                    r.slot = '0;
                end
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbgx_bus_if.sv
// Register port of the transfer unit: decodes status, selector and data.
// Produces a one-cycle start pulse for a full-strobe selector write
// accepted while idle. Assumes word-aligned byte addresses.
module dbgx_bus_if
    import dbgx_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [STRB_W-1:0] bus_wstrb,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xfer_ready,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic              start,
    output logic [IDX_W-1:0]  start_idx,
    output logic              start_dir,
    output logic [DATA_W-1:0] data_q
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'({OFS_STATUS, 2'b00});
    localparam logic [ADDR_W-1:0] A_SEL    = ADDR_W'({OFS_SEL, 2'b00});
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'({OFS_DATA, 2'b00});

    logic              hit_sel;
    logic              hit_data;
    logic [DATA_W-1:0] merged;

    assign hit_sel  = (bus_addr == A_SEL);
    assign hit_data = (bus_addr == A_DATA);

    // Accept a selector write only when full-word and no transfer pending
    assign start     = bus_wen && hit_sel && (&bus_wstrb) && xfer_ready;
    assign start_idx = bus_wdata[IDX_W-1:0];
    assign start_dir = bus_wdata[DIR_BIT];

    // Byte-lane merge of a debugger write into the data register
    always_comb begin
        merged = data_q;
        for (int b = 0; b < STRB_W; b++) begin
            if (bus_wstrb[b]) merged[8*b +: 8] = bus_wdata[8*b +: 8];
        end
    end

    // Data register: core read results take priority over bus writes
    always_ff @(posedge clk) begin
        if (!rst_n)                    data_q <= '0;
        else if (load_en)              data_q <= load_data;
        else if (bus_wen && hit_data)  data_q <= merged;
    end

    // Read mux; the selector is write-only and reads as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STATUS)  bus_rdata[RDY_BIT] = xfer_ready;
        else if (hit_data)         bus_rdata = data_q;
    end

endmodule

// File: rtl/dbgx_xfer_ctrl.sv
// Transfer sequencer: latches the routed target on a start pulse, holds
// a request to the core until it acknowledges, then returns to idle.
// Assumes the acknowledge is a single-cycle pulse while request is high.
module dbgx_xfer_ctrl
    import dbgx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic              start_dir,
    input  logic              stack_sel,
    input  logic              core_ack,
    input  logic [DATA_W-1:0] core_rdata,
    output logic              core_req,
    output logic              core_ok,
    output logic [SLOT_W-1:0] core_slot,
    output logic              core_wnr,
    output logic              xfer_ready,
    output logic              load_en,
    output logic [DATA_W-1:0] load_data
);

    xfer_state_t state_q;
    route_t      route;

    assign route = route_index(start_idx, stack_sel);

    // State and latched target of the current transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= XS_IDLE;
            core_ok   <= 1'b0;
            core_slot <= '0;
            core_wnr  <= 1'b0;
        end else begin
            case (state_q)
                XS_IDLE: if (start) begin
                    state_q   <= XS_BUSY;
                    core_ok   <= route.ok;
                    core_slot <= route.slot;
                    core_wnr  <= start_dir;
                end
                XS_BUSY: if (core_ack) state_q <= XS_IDLE;
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    // Request is held for the whole busy phase
    assign core_req   = (state_q == XS_BUSY);
    assign xfer_ready = (state_q == XS_IDLE);

    // A read completion loads the returned word into the data register
    assign load_en   = core_req && core_ack && !core_wnr;
    assign load_data = core_rdata;

endmodule

// File: rtl/dbgx_core_model.sv
// Core register file model: answers each request after a programmable
// number of cycles, commits writes at that moment and returns read data.
// Assumes the request stays high until the acknowledge is seen.
module dbgx_core_model
    import dbgx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LAT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              ok,
    input  logic [SLOT_W-1:0] slot,
    input  logic              wnr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LAT_W-1:0]  ack_lat,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [SLOT_N];
    logic [LAT_W-1:0]  cnt_q;
    logic              commit;
    logic              slot_in_range;

    assign slot_in_range = (slot < SLOT_W'(SLOT_N));
    assign commit        = req && !ack && (cnt_q == ack_lat);

    // Latency counter and single-cycle acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ack   <= 1'b0;
        end else if (commit) begin
            cnt_q <= '0;
            ack   <= 1'b1;
        end else begin
            ack <= 1'b0;
            if (req && !ack) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Read data captured at commit; unlisted targets return zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (commit)
            rdata <= (ok && slot_in_range) ? store[slot] : '0;
    end

    // One storage word per slot, written only through a listed target
    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[g] <= '0;
            else if (commit && wnr && ok && (slot == SLOT_W'(g)))
                store[g] <= wdata;
        end
    end

endmodule

// File: rtl/dbg_xfer_unit.sv
// Debug core register transfer unit top: register port, sequencer and
// core register file model. Assumes DATA_W >= 17 and ADDR_W >= 4.
module dbg_xfer_unit
    import dbgx_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int LAT_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wen,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [DATA_W/8-1:0]   bus_wstrb,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  stack_sel,
    input  logic [LAT_W-1:0]      ack_lat
);

    logic              xfer_ready;
    logic              start;
    logic [IDX_W-1:0]  start_idx;
    logic              start_dir;
    logic [DATA_W-1:0] data_q;
    logic              load_en;
    logic [DATA_W-1:0] load_data;
    logic              core_req;
    logic              core_ok;
    logic [SLOT_W-1:0] core_slot;
    logic              core_wnr;
    logic              core_ack;
    logic [DATA_W-1:0] core_rdata;

    dbgx_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wen    (bus_wen),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wstrb  (bus_wstrb),
        .bus_rdata  (bus_rdata),
        .xfer_ready (xfer_ready),
        .load_en    (load_en),
        .load_data  (load_data),
        .start      (start),
        .start_idx  (start_idx),
        .start_dir  (start_dir),
        .data_q     (data_q)
    );

    dbgx_xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_idx  (start_idx),
        .start_dir  (start_dir),
        .stack_sel  (stack_sel),
        .core_ack   (core_ack),
        .core_rdata (core_rdata),
        .core_req   (core_req),
        .core_ok    (core_ok),
        .core_slot  (core_slot),
        .core_wnr   (core_wnr),
        .xfer_ready (xfer_ready),
        .load_en    (load_en),
        .load_data  (load_data)
    );

    dbgx_core_model #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (core_req),
        .ok      (core_ok),
        .slot    (core_slot),
        .wnr     (core_wnr),
        .wdata   (data_q),
        .ack_lat (ack_lat),
        .ack     (core_ack),
        .rdata   (core_rdata)
    );

endmodule

// File: rtl/dbgx_xfer_chk.sv
// Checker for the transfer unit, attached to the top with bind.
module dbgx_xfer_chk
    import dbgx_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int STRB_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [STRB_W-1:0] bus_wstrb,
    input logic              ready,
    input logic              core_req,
    input logic              core_ack
);

    logic sel_wr;
    assign sel_wr = bus_wen && (bus_addr == ADDR_W'({OFS_SEL, 2'b00}));

    // R7
    sel_accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && (&bus_wstrb) && ready) |=> !ready);

    // R8
    partial_sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !(&bus_wstrb) && ready) |=> ready);

    // R9
    pending_req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !core_ack) |=> core_req);

    // R7
    ack_within_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |-> core_req);

    // R7
    ack_restores_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_ack) |=> ready);

    // R9
    busy_means_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !core_ack) |=> !ready);

endmodule

bind dbg_xfer_unit dbgx_xfer_chk #(.ADDR_W(ADDR_W), .STRB_W(DATA_W/8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wstrb (bus_wstrb),
    .ready     (xfer_ready),
    .core_req  (core_req),
    .core_ack  (core_ack)
);

// File: tb/dbg_xfer_unit_test.sv
module dbg_xfer_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;
    logic        stack_sel = 1'b0;
    logic [2:0]  ack_lat = 3'd0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] m_slot [19];
    logic [31:0] m_data;

    always #2.5 clk = ~clk;

    dbg_xfer_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
        .stack_sel(stack_sel), .ack_lat(ack_lat)
    );

    // Index to model slot, -1 for unlisted (R3, R4, R5, R6)
    function automatic int route(input int idx, input bit ss);
        if (idx <= 12) return idx;
        case (idx)
            13: return ss ? 17 : 16;
            14: return 13;
            15: return 14;
            16: return 15;
            17: return 16;
            18: return 17;
            20: return 18;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old,
                                          input logic [31:0] nw,
                                          input logic [3:0] s);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wen = 1'b0; bus_wstrb = '0;
    endtask

    task automatic wr_data(input logic [31:0] d, input logic [3:0] s);
        wr(4'h8, d, s);
        m_data = merge(m_data, d, s);
    endtask

    // One transfer; also checks the ready-low window length (R7)
    task automatic xfer(input int idx, input bit wnr, input string req);
        logic [31:0] v;
        int n = 0;
        int sl = route(idx, stack_sel);
        wr(4'h4, (32'(wnr) << 16) | 32'(idx), 4'hF);
        forever begin
            rd(4'h0, v);
            if (v[16] || n > 40) break;
            n++;
            @(negedge clk);
        end
        check({req, " R7 ready-low cycles"}, 32'(n), 32'(ack_lat) + 32'd2);
        if (wnr) begin
            if (sl >= 0) m_slot[sl] = m_data;
        end else begin
            m_data = (sl >= 0) ? m_slot[sl] : 32'h0;
        end
        rd(4'h8, v);
        check({req, " data register"}, v, m_data);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < 19; i++) m_slot[i] = '0;
        m_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R10: reset state and read-only views
        rd(4'h0, v); check("R1 status after reset", v, 32'h0001_0000);
        rd(4'h8, v); check("R1 data after reset", v, 32'h0);
        rd(4'h4, v); check("R10 selector reads zero", v, 32'h0);
        xfer(5, 1'b0, "R1 core reg reset read");
        xfer(20, 1'b0, "R1 packed word reset read");

        // R2, R3: write each listed index with a distinct word, read back
        for (int i = 0; i <= 20; i++) begin
            if (i == 13 || i == 19) continue;
            wr_data(32'hC0DE_0000 + 32'(i * 257), 4'hF);
            xfer(i, 1'b1, "R2 write");
        end
        for (int i = 0; i <= 20; i++) begin
            if (i == 13 || i == 19) continue;
            xfer(i, 1'b0, "R3 readback");
        end

        // R4: stack alias routing
        stack_sel = 1'b0; xfer(13, 1'b0, "R4 alias main");
        check("R4 alias main value", m_data, 32'hC0DE_0000 + 32'(17 * 257));
        stack_sel = 1'b1; xfer(13, 1'b0, "R4 alias process");
        check("R4 alias process value", m_data, 32'hC0DE_0000 + 32'(18 * 257));
        wr_data(32'h5A5A_1234, 4'hF);
        xfer(13, 1'b1, "R4 alias write");
        stack_sel = 1'b0; xfer(18, 1'b0, "R4 process via name");
        xfer(17, 1'b0, "R4 main untouched");

        // R5: packed mask word, control byte at 31:24, primask at 7:0
        wr_data(32'hA1B2_C3D4, 4'hF);
        xfer(20, 1'b1, "R5 packed write");
        wr_data(32'h0, 4'hF);
        xfer(20, 1'b0, "R5 packed read");
        check("R5 control field", {24'h0, m_data[31:24]}, 32'hA1);
        check("R5 primask field", {24'h0, m_data[7:0]}, 32'hD4);

        // R6: unlisted indices
        wr_data(32'hDEAD_BEEF, 4'hF);
        xfer(19, 1'b1, "R6 write dropped");
        xfer(19, 1'b0, "R6 read zero");
        wr_data(32'h1111_2222, 4'hF);
        xfer(25, 1'b0, "R6 high index read zero");
        for (int i = 0; i <= 20; i++) begin
            if (i == 19) continue;
            xfer(i, 1'b0, "R6 no slot disturbed");
        end

        // R7: every latency setting
        for (int l = 0; l < 8; l++) begin
            ack_lat = 3'(l);
            xfer(l, 1'b0, "R7 latency sweep");
        end

        // R8: partial-strobe selector write ignored
        ack_lat = 3'd2;
        wr_data(32'h7777_8888, 4'hF);
        wr(4'h4, 32'd3, 4'b0111);
        rd(4'h0, v); check("R8 ready stays set", v, 32'h0001_0000);
        repeat (12) @(negedge clk);
        rd(4'h8, v); check("R8 data unchanged", v, 32'h7777_8888);

        // R9: selector write during a pending transfer ignored
        ack_lat = 3'd7;
        wr_data(32'h9999_AAAA, 4'hF);
        wr(4'h4, 32'd3, 4'hF);
        wr(4'h4, 32'h0001_0006, 4'hF);
        rd(4'h0, v); check("R9 still busy", v, 32'h0);
        repeat (12) @(negedge clk);
        rd(4'h0, v); check("R9 ready after first", v, 32'h0001_0000);
        m_data = m_slot[3];
        rd(4'h8, v); check("R9 first read result", v, m_data);
        xfer(6, 1'b0, "R9 second target untouched");

        // R11: byte strobes on the data register
        wr_data(32'hFFFF_FFFF, 4'hF);
        wr_data(32'h1234_5678, 4'b0101);
        rd(4'h8, v); check("R11 byte merge", v, 32'hFF34_FF78);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int op = $urandom_range(0, 3);
            ack_lat = 3'($urandom_range(0, 7));
            stack_sel = 1'($urandom_range(0, 1));
            if (op == 0) wr_data($urandom, 4'($urandom_range(1, 15)));
            else xfer($urandom_range(0, 31), 1'($urandom_range(0, 1)), "R2 R3 random");
        end
        rd(4'h0, v); check("R10 status other bits", v, 32'h0001_0000);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule